// File: doc/BRIEF.md
# Host Bus Parity Generator and Checker

This block protects the control and address groups of a split-transaction processor bus with even parity. When the bridge is the agent driving a group, it supplies that group's parity bit. When another agent drives the group, it recomputes the parity from the sampled lines, compares it with the received parity bit, and records any mismatch.

The bus is low-true. Parity is taken on electrical levels: a group together with its parity line always has an even number of asserted (low) lines. There are four parity groups. The request group is the address strobe plus the five request-code lines. The address is split into an upper group (A35..A24) and a lower group (A23..A3). The response group is the three response-code lines. A detected error always sets a sticky status bit, which software clears by writing one to it. Each group also has an enable bit. When that bit is set, the error additionally produces a one-cycle pulse on a reporting output.

Top module: `hbp_parity_unit`

## Requirements
- R1: `rp_n_out` is generated so that `{ads_n, req_n, rp_n_out}` always holds an even number of zero (asserted) lines.
- R2: `ap_n_out[1]` makes `addr_n[32:21]` (A35..A24) plus itself hold an even number of zeros. `ap_n_out[0]` does the same for `addr_n[20:0]` (A23..A3). Index i of `addr_n` carries address bit i+3.
- R3: `rsp_par_n_out` makes `{rsp_n, rsp_par_n_out}` hold an even number of zeros.
- R4: When `drive_req`=0 and `ads_n`=0, a mismatch between `rp_n_in` and the expected request parity sets status bit 0 at the next clock edge.
- R5: In the same strobe cycle, a mismatch on `ap_n_in[0]` sets status bit 1 and a mismatch on `ap_n_in[1]` sets status bit 2. Each address half is checked independently.
- R6: When `drive_rsp`=0 and `rsp_vld`=1, a mismatch on `rsp_par_n_in` sets status bit 3 at the next clock edge.
- R7: No error is logged for a group while the bridge drives it (`drive_req`=1 or `drive_rsp`=1), or while its strobe is inactive (`ads_n`=1, or `rsp_vld`=0).
- R8: Status bits are sticky. A cycle with `clr_we`=1 clears exactly the bits set in `clr_mask`. If a new error arrives for a bit in the same cycle that bit is cleared, the bit stays set.
- R9: `err_pulse[i]` is high for one cycle, at the same edge that status bit i is set, only if `err_en[i]` was 1 in the detecting cycle. With the enable at 0, the status bit is still set.
- R10: While `rst_n` is low at a clock edge, `err_sts` and `err_pulse` become all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drive_req | input | 1 | 1 = bridge drives request/address groups |
| drive_rsp | input | 1 | 1 = bridge drives response group |
| ads_n | input | 1 | Address strobe, low-true |
| req_n | input | 5 | Request code, low-true |
| addr_n | input | 33 | Address A35..A3, low-true |
| rsp_n | input | 3 | Response code, low-true |
| rsp_vld | input | 1 | Response phase sample strobe, high-true |
| rp_n_in | input | 1 | Received request parity |
| ap_n_in | input | 2 | Received address parity (1 = upper, 0 = lower) |
| rsp_par_n_in | input | 1 | Received response parity |
| rp_n_out | output | 1 | Generated request parity |
| ap_n_out | output | 2 | Generated address parity |
| rsp_par_n_out | output | 1 | Generated response parity |
| err_en | input | 4 | Per-group pulse enables |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 4 | Status bits to clear |
| err_pulse | output | 4 | One-cycle error reports |
| err_sts | output | 4 | Sticky error status |

## Verification
A wrong parity tree or a group with wrong coverage shows on the generated parity outputs in the same cycle, before any clock edge. It also shows as a spurious or missing status bit one edge after a strobed check. A bad status register shows in several ways: a bit that drops without a matching clear, a bit that a clear leaves behind, or a bit that the wrong group sets. Each of these appears on `err_sts` at the edge that follows the stimulus. Gating faults show one edge after the detecting cycle, as a pulse without its enable, or as a check that fires while the bridge drives the group.

// File: rtl/hbp_pkg.sv
// Package: shared widths and status bit positions for the host bus parity unit.
// Assumes address group index i carries address bit i+3.
package hbp_pkg;
    localparam int REQ_W     = 5;
    localparam int ADDR_W    = 33;
    localparam int ADDR_LO_W = 21;
    localparam int RSP_W     = 3;
    localparam int NGRP      = 4;

    typedef enum int {
        GRP_REQ     = 0,
        GRP_ADDR_LO = 1,
        GRP_ADDR_HI = 2,
        GRP_RSP     = 3
    } grp_e;
endpackage

// File: rtl/hbp_par_gen.sv
// Module: low-true even parity generator for one group.
// Output is driven low (asserted) when the group has an odd number of low
// lines, so that group plus parity line always has an even count of lows.
module hbp_par_gen #(
    parameter int W = 4
) (
    input  logic [W-1:0] grp_n,
    output logic         par_n
);
    // Parity of asserted (low) lines, inverted onto the low-true output.
    always_comb begin
        par_n = ~(^(~grp_n));
    end
endmodule

// File: rtl/hbp_err_log.sv
// Module: sticky error status with write-one-to-clear and gated pulses.
// Assumes det is valid for one cycle per detected error; set wins over clear.
module hbp_err_log #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] det,
    input  logic [N-1:0] en,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] sts,
    output logic [N-1:0] pulse
);
    logic [N-1:0] clr_eff;

    // Clear vector is active only on a write strobe.
    always_comb begin
        clr_eff = clr_we ? clr_mask : '0;
    end

    // Sticky status update and one-cycle report pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts   <= '0;
            pulse <= '0;
        end else begin
            sts   <= (sts & ~clr_eff) | det;
            pulse <= det & en;
        end
    end
endmodule

// File: rtl/hbp_parity_unit.sv
// Module: top of the host bus parity generator/checker.
// Generates parity for request, address halves and response groups, and
// checks received parity in the strobe cycle when another agent drives.
// Assumes all bus lines low-true; rsp_vld is a high-true sample strobe.
module hbp_parity_unit
    import hbp_pkg::*;
#(
    parameter int REQ_BITS  = REQ_W,
    parameter int ADDR_BITS = ADDR_W,
    parameter int ADDR_LO   = ADDR_LO_W,
    parameter int RSP_BITS  = RSP_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 drive_req,
    input  logic                 drive_rsp,
    input  logic                 ads_n,
    input  logic [REQ_BITS-1:0]  req_n,
    input  logic [ADDR_BITS-1:0] addr_n,
    input  logic [RSP_BITS-1:0]  rsp_n,
    input  logic                 rsp_vld,
    input  logic                 rp_n_in,
    input  logic [1:0]           ap_n_in,
    input  logic                 rsp_par_n_in,
    output logic                 rp_n_out,
    output logic [1:0]           ap_n_out,
    output logic                 rsp_par_n_out,
    input  logic [NGRP-1:0]      err_en,
    input  logic                 clr_we,
    input  logic [NGRP-1:0]      clr_mask,
    output logic [NGRP-1:0]      err_pulse,
    output logic [NGRP-1:0]      err_sts
);
    localparam int ADDR_HI = ADDR_BITS - ADDR_LO;

    logic            req_chk;
    logic            rsp_chk;
    logic [NGRP-1:0] det;

    hbp_par_gen #(.W(REQ_BITS + 1)) u_gen_req (
        .grp_n ({ads_n, req_n}),
        .par_n (rp_n_out)
    );

    hbp_par_gen #(.W(ADDR_LO)) u_gen_alo (
        .grp_n (addr_n[ADDR_LO-1:0]),
        .par_n (ap_n_out[0])
    );

    hbp_par_gen #(.W(ADDR_HI)) u_gen_ahi (
        .grp_n (addr_n[ADDR_BITS-1:ADDR_LO]),
        .par_n (ap_n_out[1])
    );

    hbp_par_gen #(.W(RSP_BITS)) u_gen_rsp (
        .grp_n (rsp_n),
        .par_n (rsp_par_n_out)
    );

    // Checks apply only to received groups in their strobe cycle.
    always_comb begin
        req_chk = !drive_req && !ads_n;
        rsp_chk = !drive_rsp && rsp_vld;
    end

    // Per-group mismatch detection against the locally computed parity.
    always_comb begin
        det              = '0;
        det[GRP_REQ]     = req_chk && (rp_n_in      != rp_n_out);
        det[GRP_ADDR_LO] = req_chk && (ap_n_in[0]   != ap_n_out[0]);
        det[GRP_ADDR_HI] = req_chk && (ap_n_in[1]   != ap_n_out[1]);
        det[GRP_RSP]     = rsp_chk && (rsp_par_n_in != rsp_par_n_out);
    end

    hbp_err_log #(.N(NGRP)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .det      (det),
        .en       (err_en),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .sts      (err_sts),
        .pulse    (err_pulse)
    );
endmodule

// File: rtl/hbp_checker.sv
// Module: assertion checker bound to hbp_parity_unit.
// Assumes default package widths.
module hbp_checker
    import hbp_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                drive_req,
    input logic                drive_rsp,
    input logic                ads_n,
    input logic [REQ_W-1:0]    req_n,
    input logic [ADDR_W-1:0]   addr_n,
    input logic [RSP_W-1:0]    rsp_n,
    input logic                rsp_vld,
    input logic                rp_n_out,
    input logic [1:0]          ap_n_out,
    input logic                rsp_par_n_out,
    input logic [NGRP-1:0]     err_en,
    input logic                clr_we,
    input logic [NGRP-1:0]     clr_mask,
    input logic [NGRP-1:0]     err_pulse,
    input logic [NGRP-1:0]     err_sts
);
    p_req_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~{ads_n, req_n, rp_n_out}) % 2) == 0);

    p_addr_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (($countones(~{addr_n[ADDR_W-1:ADDR_LO_W], ap_n_out[1]}) % 2) == 0) &&
        (($countones(~{addr_n[ADDR_LO_W-1:0], ap_n_out[0]}) % 2) == 0));

    p_rsp_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~{rsp_n, rsp_par_n_out}) % 2) == 0);

    p_no_req_chk_driving_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_req || ads_n) |=> (err_pulse[2:0] == 3'b000));

    p_no_rsp_chk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_rsp || !rsp_vld) |=> !err_pulse[3]);

    p_pulse_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (~err_en) == 4'b1111 |=> err_pulse == 4'b0000);

    p_pulse_has_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse & ~err_sts) == 4'b0000);

    for (genvar g = 0; g < NGRP; g++) begin : g_sticky
        p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (err_sts[g] && !(clr_we && clr_mask[g])) |=> err_sts[g]);
    end
endmodule

bind hbp_parity_unit hbp_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .drive_req     (drive_req),
    .drive_rsp     (drive_rsp),
    .ads_n         (ads_n),
    .req_n         (req_n),
    .addr_n        (addr_n),
    .rsp_n         (rsp_n),
    .rsp_vld       (rsp_vld),
    .rp_n_out      (rp_n_out),
    .ap_n_out      (ap_n_out),
    .rsp_par_n_out (rsp_par_n_out),
    .err_en        (err_en),
    .clr_we        (clr_we),
    .clr_mask      (clr_mask),
    .err_pulse     (err_pulse),
    .err_sts       (err_sts)
);

// File: tb/hbp_parity_unit_test.sv
// Directed bench for hbp_parity_unit: one task per scenario.
module hbp_parity_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        drive_req, drive_rsp, ads_n, rsp_vld;
    logic [4:0]  req_n;
    logic [32:0] addr_n;
    logic [2:0]  rsp_n;
    logic        rp_n_in, rsp_par_n_in;
    logic [1:0]  ap_n_in;
    logic        rp_n_out, rsp_par_n_out;
    logic [1:0]  ap_n_out;
    logic [3:0]  err_en, clr_mask, err_pulse, err_sts;
    logic        clr_we;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    hbp_parity_unit uut (
        .clk(clk), .rst_n(rst_n), .drive_req(drive_req), .drive_rsp(drive_rsp),
        .ads_n(ads_n), .req_n(req_n), .addr_n(addr_n), .rsp_n(rsp_n),
        .rsp_vld(rsp_vld), .rp_n_in(rp_n_in), .ap_n_in(ap_n_in),
        .rsp_par_n_in(rsp_par_n_in), .rp_n_out(rp_n_out), .ap_n_out(ap_n_out),
        .rsp_par_n_out(rsp_par_n_out), .err_en(err_en), .clr_we(clr_we),
        .clr_mask(clr_mask), .err_pulse(err_pulse), .err_sts(err_sts)
    );

    // Expected low-true parity: low when the low-line count of the first w bits is odd.
    function automatic logic exp_par(input logic [63:0] v, input int w);
        int zeros = 0;
        for (int i = 0; i < w; i++) if (!v[i]) zeros++;
        return (zeros % 2) ? 1'b0 : 1'b1;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    // Idle bus with correct received parity.
    task automatic idle;
        drive_req = 0; drive_rsp = 0; ads_n = 1; rsp_vld = 0;
        req_n = 5'h1f; addr_n = '1; rsp_n = 3'h7;
        rp_n_in = exp_par({58'h0, ads_n, req_n}, 6);
        ap_n_in = {exp_par({31'h0, addr_n[32:21]}, 12), exp_par({31'h0, addr_n[20:0]}, 21)};
        rsp_par_n_in = exp_par({61'h0, rsp_n}, 3);
        clr_we = 0; clr_mask = 0;
    endtask

    task automatic set_good_req(input logic [4:0] rq, input logic [32:0] a);
        ads_n = 0; req_n = rq; addr_n = a;
        rp_n_in = exp_par({58'h0, 1'b0, rq}, 6);
        ap_n_in = {exp_par({52'h0, a[32:21]}, 12), exp_par({43'h0, a[20:0]}, 21)};
    endtask

    task automatic clear_all;
        idle(); clr_we = 1; clr_mask = 4'hf; step(); idle();
    endtask

    task automatic t_reset;
        idle(); err_en = 4'hf; rst_n = 0;
        rp_n_in = ~rp_n_in; ads_n = 0;
        step(); step();
        chk("R10 status after reset", err_sts, 4'h0);
        chk("R10 pulse after reset", err_pulse, 4'h0);
        idle(); rst_n = 1; step();
    endtask

    task automatic t_gen;
        logic [4:0]  rq [4] = '{5'h00, 5'h15, 5'h1f, 5'h0e};
        logic [32:0] ad [4] = '{33'h0, 33'h1_2345_6789, 33'h1_ffff_ffff, 33'h0_0020_0001};
        logic [2:0]  rs [4] = '{3'h0, 3'h5, 3'h7, 3'h2};
        for (int k = 0; k < 4; k++) begin
            idle(); drive_req = 1; drive_rsp = 1;
            ads_n = k[0]; req_n = rq[k]; addr_n = ad[k]; rsp_n = rs[k];
            #1;
            chk("R1 request parity", rp_n_out, exp_par({58'h0, ads_n, req_n}, 6));
            chk("R2 addr upper parity", ap_n_out[1], exp_par({52'h0, addr_n[32:21]}, 12));
            chk("R2 addr lower parity", ap_n_out[0], exp_par({43'h0, addr_n[20:0]}, 21));
            chk("R3 response parity", rsp_par_n_out, exp_par({61'h0, rsp_n}, 3));
            step();
        end
        idle(); step();
        chk("R7 no log while driving", err_sts, 4'h0);
    endtask

    task automatic t_req_addr_chk;
        clear_all();
        idle(); set_good_req(5'h0b, 33'h0_1234_5678); step();
        idle(); step();
        chk("R4 good request no error", err_sts, 4'h0);
        set_good_req(5'h13, 33'h1_0f0f_0f0f); rp_n_in = ~rp_n_in; step();
        chk("R4 req error status", err_sts, 4'h1);
        chk("R4 req error pulse", err_pulse, 4'h1);
        idle(); step();
        chk("R9 pulse one cycle", err_pulse, 4'h0);
        clear_all();
        set_good_req(5'h1c, 33'h0_00ab_cdef); ap_n_in[0] = ~ap_n_in[0]; step();
        chk("R5 lower addr error", err_sts, 4'h2);
        clear_all();
        set_good_req(5'h1c, 33'h1_abcd_0000); ap_n_in[1] = ~ap_n_in[1]; step();
        chk("R5 upper addr error", err_sts, 4'h4);
        idle(); step();
        clear_all();
    endtask

    task automatic t_rsp_chk;
        idle(); rsp_n = 3'h4; rsp_vld = 1; rsp_par_n_in = exp_par({61'h0, rsp_n}, 3); step();
        chk("R6 good response no error", err_sts, 4'h0);
        rsp_n = 3'h1; rsp_par_n_in = ~exp_par({61'h0, rsp_n}, 3); step();
        chk("R6 response error status", err_sts, 4'h8);
        chk("R6 response error pulse", err_pulse, 4'h8);
        clear_all();
    endtask

    task automatic t_ignore;
        idle(); drive_req = 1; ads_n = 0; rp_n_in = ~rp_n_in; ap_n_in = ~ap_n_in; step();
        idle(); ads_n = 1; rp_n_in = ~rp_n_in; ap_n_in = ~ap_n_in; step();
        idle(); rsp_vld = 0; rsp_par_n_in = ~rsp_par_n_in; step();
        idle(); drive_rsp = 1; rsp_vld = 1; rsp_par_n_in = ~rsp_par_n_in; step();
        chk("R7 driven/idle groups ignored pulse", err_pulse, 4'h0);
        idle(); step();
        chk("R7 driven/idle groups ignored status", err_sts, 4'h0);
    endtask

    task automatic t_sticky;
        idle(); set_good_req(5'h0, 33'h0); rp_n_in = ~rp_n_in;
        rsp_vld = 1; rsp_par_n_in = ~rsp_par_n_in; step();
        idle(); step(); step();
        chk("R8 status holds", err_sts, 4'h9);
        clr_we = 1; clr_mask = 4'h1; step();
        chk("R8 selective clear", err_sts, 4'h8);
        clr_we = 0; clr_mask = 4'h8; step();
        chk("R8 mask without write ignored", err_sts, 4'h8);
        clr_we = 1; clr_mask = 4'h8; rsp_vld = 1; rsp_par_n_in = ~rsp_par_n_in; step();
        chk("R8 set wins over clear", err_sts, 4'h8);
        clear_all();
        chk("R8 clear all", err_sts, 4'h0);
    endtask

    task automatic t_enable;
        err_en = 4'h0;
        idle(); set_good_req(5'h07, 33'h0_5555_aaaa); rp_n_in = ~rp_n_in; step();
        chk("R9 disabled no pulse", err_pulse, 4'h0);
        chk("R9 disabled still logs", err_sts, 4'h1);
        err_en = 4'h1;
        idle(); set_good_req(5'h07, 33'h0_5555_aaaa); rp_n_in = ~rp_n_in;
        ap_n_in[0] = ~ap_n_in[0]; step();
        chk("R9 per-group enable", err_pulse, 4'h1);
        chk("R9 both logged", err_sts, 4'h3);
        err_en = 4'hf;
        clear_all();
    endtask

    initial begin
        t_reset();
        t_gen();
        t_req_addr_chk();
        t_rsp_chk();
        t_ignore();
        t_sticky();
        t_enable();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule